// File: doc/BRIEF.md
# Load-Hit Speculation Window Controller

This block sits beside an issue queue and decides whether consumers of an integer load may issue before the data cache has reported hit or miss. A saturating hit/miss history counter picks between the short speculative latency and a longer safe latency. While the counter predicts hits, every eligible load opens a two-cycle window. Any instruction the queue issues during an open window is tagged with the loads whose windows are open. Its queue entry then stays held with its request inhibited, whether or not it uses the load data.

The hit result comes back three cycles after load issue. On a hit, held entries whose tagged loads have all resolved are removed from the queue by a one-cycle strobe. On a miss, every entry tagged with that load gets a one-cycle abort strobe and is released, so it may request again in the next cycle. Loads that write the zero register and floating-point loads open no window and leave the counter unchanged. Floating-point loads report their own fixed latency.

Top module: `ldspec_window_ctl`

## Requirements
- R1: After reset the counter is at its maximum (15, predicting hits), no entry is inhibited, no window is open and an integer load reports latency 3.
- R2: `lat_o` is 4 for a floating-point load. For an integer load it is 3 when bit 3 of the counter is 1 and 5 when that bit is 0.
- R3: An integer load issued in cycle t, with a destination other than 31 and counter bit 3 set, drives `win_open_o` high in cycles t+1 and t+2. In safe mode no window opens.
- R4: An entry issued while `win_open_o` is high shows `inhibit_o` high from the next cycle until its release, whatever its dependence on the load.
- R5: `res_hit_i` is sampled in cycle t+3 for the load issued in cycle t. On a hit, `remove_o` pulses in that cycle for each held entry whose last pending tagged load this was. Its `inhibit_o` is low in the next cycle.
- R6: On a miss, `abort_o` pulses in that cycle for every entry tagged with the load. Its `inhibit_o` is low in the next cycle, so the entry may request again.
- R7: Each tracked result changes the counter by +1 on a hit, saturating at 15, and by -2 on a miss, clamping at 0.
- R8: A load with destination 31, or a floating-point load, opens no window and does not change the counter. `res_hit_i` is ignored in cycles that resolve no tracked load.
- R9: An entry issued while several windows are open is removed only after all of those loads hit. It is aborted on the first miss among them.
- R10: An entry issued while no window is open is never inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ld_issue_i | input | 1 | A load issues this cycle |
| ld_fp_i | input | 1 | The issuing load is floating-point |
| ld_dst_i | input | 5 | Destination register of the issuing load |
| res_hit_i | input | 1 | Hit (1) or miss (0) for the load issued three cycles earlier |
| iss_valid_i | input | 1 | The queue issues an entry this cycle |
| iss_idx_i | input | 3 | Index of the issued entry |
| lat_o | output | 3 | Load-use latency for the issuing load |
| win_open_o | output | 1 | At least one speculative window is open |
| inhibit_o | output | 8 | Per-entry request inhibit |
| remove_o | output | 8 | Per-entry remove strobe |
| abort_o | output | 8 | Per-entry abort strobe |

## Verification
Some properties are checked on every cycle. Remove and abort never strike the same entry. Aborts only come with a miss and removals only with a hit. An aborted entry is released on the next cycle. An entry issued in a window is held, and one issued outside a window is not. Counter steps are only +1, -2 or a clamp to zero, and floating-point latency is fixed. Other behaviour needs the bench's scenarios and its cycle-indexed reference model: which loads own a window, mixed hit/miss results over overlapping windows, the counter crossing its midpoint into safe mode and back, and the zero-register and floating-point exemptions.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;
   // Result of the load that resolves this cycle, as seen by the entries
   typedef struct packed {
      logic fire;
      logic hit;
   } ldspec_res_t;

   function automatic int lat_bits(input int max_lat);
      return $clog2(max_lat + 1);
   endfunction
endpackage

// File: rtl/ldspec_pred.sv
module ldspec_pred #(
   parameter int CNT_W = 4,
   parameter int INC   = 1,
   parameter int DEC   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             upd_i,
   input  logic             hit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             spec_on_o
);
   localparam logic [CNT_W-1:0] MAX   = '1;
   localparam logic [CNT_W-1:0] INC_V = CNT_W'(INC);
   localparam logic [CNT_W-1:0] DEC_V = CNT_W'(DEC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= MAX;
      end else if (upd_i) begin
         if (hit_i) cnt_q <= (cnt_q > MAX - INC_V) ? MAX : cnt_q + INC_V;
         else       cnt_q <= (cnt_q < DEC_V) ? '0 : cnt_q - DEC_V;
      end
   end

   assign cnt_o     = cnt_q;
   assign spec_on_o = cnt_q[CNT_W-1];
endmodule

// File: rtl/ldspec_slots.sv
module ldspec_slots #(
   parameter int NSLOT = 3,
   localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             new_trk_i,
   input  logic             new_spec_i,
   output logic [NSLOT-1:0] open_o,
   output logic [NSLOT-1:0] rbit_o,
   output logic             res_trk_o,
   output logic             res_spec_o
);
   logic [PTR_W-1:0] ptr_q;
   logic [NSLOT-1:0] trk_q, spec_q;

   // The slot under the pointer was filled NSLOT cycles ago and resolves now;
   // every other live speculative slot is still inside its window.
   always_comb begin
      for (int s = 0; s < NSLOT; s++) rbit_o[s] = (ptr_q == PTR_W'(s));
   end

   assign open_o     = spec_q & ~rbit_o;
   assign res_trk_o  = |(trk_q & rbit_o);
   assign res_spec_o = |(spec_q & rbit_o);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ptr_q  <= '0;
         trk_q  <= '0;
         spec_q <= '0;
      end else begin
         for (int s = 0; s < NSLOT; s++) begin
            if (rbit_o[s]) begin
               trk_q[s]  <= new_trk_i;
               spec_q[s] <= new_spec_i;
            end
         end
         ptr_q <= (ptr_q == PTR_W'(NSLOT - 1)) ? '0 : ptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/ldspec_entry.sv
module ldspec_entry #(
   parameter int NSLOT = 3
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      iss_i,
   input  logic [NSLOT-1:0]          open_i,
   input  logic [NSLOT-1:0]          rbit_i,
   input  ldspec_pkg::ldspec_res_t   res_i,
   output logic                      inhibit_o,
   output logic                      remove_o,
   output logic                      abort_o
);
   logic [NSLOT-1:0] tag_q, tag_d, left;

   always_comb begin
      left     = tag_q & ~rbit_i;
      tag_d    = tag_q;
      remove_o = 1'b0;
      abort_o  = 1'b0;
      if (res_i.fire && |(tag_q & rbit_i)) begin
         if (res_i.hit) begin
            tag_d    = left;
            remove_o = (left == '0);
         end else begin
            tag_d   = '0;
            abort_o = 1'b1;
         end
      end
      if (iss_i) tag_d = open_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) tag_q <= '0;
      else         tag_q <= tag_d;
   end

   assign inhibit_o = |tag_q;
endmodule

// File: rtl/ldspec_window_ctl.sv
module ldspec_window_ctl #(
   parameter int NENT     = 8,
   parameter int REG_W    = 5,
   parameter int ZERO_REG = 31,
   parameter int CNT_W    = 4,
   parameter int WIN_LEN  = 2,
   parameter int LAT_SPEC = 3,
   parameter int LAT_SAFE = 5,
   parameter int LAT_FP   = 4,
   localparam int IDX_W   = $clog2(NENT),
   localparam int NSLOT   = WIN_LEN + 1,
   localparam int LAT_W   = ldspec_pkg::lat_bits(LAT_SAFE)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ld_issue_i,
   input  logic             ld_fp_i,
   input  logic [REG_W-1:0] ld_dst_i,
   input  logic             res_hit_i,
   input  logic             iss_valid_i,
   input  logic [IDX_W-1:0] iss_idx_i,
   output logic [LAT_W-1:0] lat_o,
   output logic             win_open_o,
   output logic [NENT-1:0]  inhibit_o,
   output logic [NENT-1:0]  remove_o,
   output logic [NENT-1:0]  abort_o
);
   if (NENT < 2)                          begin : g_bad_nent  $error("NENT must be at least 2");            end
   if (WIN_LEN < 1)                       begin : g_bad_win   $error("WIN_LEN must be at least 1");         end
   if (CNT_W < 2)                         begin : g_bad_cnt   $error("CNT_W must be at least 2");           end
   if (ZERO_REG >= (1 << REG_W))          begin : g_bad_zero  $error("ZERO_REG does not fit REG_W");        end
   if (LAT_SPEC > LAT_SAFE || LAT_FP > LAT_SAFE) begin : g_bad_lat $error("LAT_SAFE must be the largest"); end

   logic [CNT_W-1:0] pred_cnt;
   logic             spec_on, elig, res_trk, res_spec;
   logic [NSLOT-1:0] open_mask, rbit;
   ldspec_pkg::ldspec_res_t res;

   assign elig = ld_issue_i && !ld_fp_i && (ld_dst_i != REG_W'(ZERO_REG));

   ldspec_pred #(.CNT_W(CNT_W), .INC(1), .DEC(2)) u_pred (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .upd_i(res_trk), .hit_i(res_hit_i),
      .cnt_o(pred_cnt), .spec_on_o(spec_on)
   );

   ldspec_slots #(.NSLOT(NSLOT)) u_slots (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .new_trk_i(elig), .new_spec_i(elig && spec_on),
      .open_o(open_mask), .rbit_o(rbit),
      .res_trk_o(res_trk), .res_spec_o(res_spec)
   );

   assign res.fire   = res_spec;
   assign res.hit    = res_hit_i;
   assign win_open_o = |open_mask;
   assign lat_o      = ld_fp_i ? LAT_W'(LAT_FP) : (spec_on ? LAT_W'(LAT_SPEC) : LAT_W'(LAT_SAFE));

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      ldspec_entry #(.NSLOT(NSLOT)) u_ent (
         .clk_i(clk_i), .rst_ni(rst_ni),
         .iss_i(iss_valid_i && (iss_idx_i == IDX_W'(e))),
         .open_i(open_mask), .rbit_i(rbit), .res_i(res),
         .inhibit_o(inhibit_o[e]), .remove_o(remove_o[e]), .abort_o(abort_o[e])
      );
   end
endmodule

// File: rtl/ldspec_window_chk.sv
module ldspec_window_chk #(
   parameter int NENT   = 8,
   parameter int CNT_W  = 4,
   parameter int LAT_W  = 3,
   parameter int LAT_FP = 4,
   localparam int IDX_W = $clog2(NENT)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ld_fp_i,
   input logic             res_hit_i,
   input logic             iss_valid_i,
   input logic [IDX_W-1:0] iss_idx_i,
   input logic [LAT_W-1:0] lat_o,
   input logic             win_open_o,
   input logic [NENT-1:0]  inhibit_o,
   input logic [NENT-1:0]  remove_o,
   input logic [NENT-1:0]  abort_o,
   input logic [CNT_W-1:0] cnt_i
);
   logic [NENT-1:0] iss_sel;
   always_comb begin
      for (int e = 0; e < NENT; e++) iss_sel[e] = iss_valid_i && (iss_idx_i == IDX_W'(e));
   end

   assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (remove_o & abort_o) == '0);
   assert_remove_on_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|remove_o) |-> res_hit_i);
   assert_abort_on_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|abort_o) |-> !res_hit_i);
   assert_abort_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(abort_o & ~iss_sel)) |=> ((inhibit_o & $past(abort_o & ~iss_sel)) == '0));
   assert_hold_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_i && win_open_o) |=> ((inhibit_o & $past(iss_sel)) == $past(iss_sel)));
   assert_free_outside_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_i && !win_open_o) |=> ((inhibit_o & $past(iss_sel)) == '0));
   assert_fp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_fp_i |-> (int'(lat_o) == LAT_FP));
   assert_ctr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i != $past(cnt_i)) |->
         ((int'(cnt_i) == int'($past(cnt_i)) + 1) ||
          (int'(cnt_i) + 2 == int'($past(cnt_i))) || (cnt_i == '0)));
endmodule

bind ldspec_window_ctl ldspec_window_chk #(
   .NENT(NENT), .CNT_W(CNT_W), .LAT_W(LAT_W), .LAT_FP(LAT_FP)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .ld_fp_i(ld_fp_i), .res_hit_i(res_hit_i),
   .iss_valid_i(iss_valid_i), .iss_idx_i(iss_idx_i), .lat_o(lat_o),
   .win_open_o(win_open_o), .inhibit_o(inhibit_o), .remove_o(remove_o),
   .abort_o(abort_o), .cnt_i(pred_cnt)
);

// File: tb/tb_ldspec_window_ctl.sv
`timescale 1ns/1ps
module tb_ldspec_window_ctl;
   localparam int NENT = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_issue = 1'b0, ld_fp = 1'b0, res_hit = 1'b0, iss_valid = 1'b0;
   logic [4:0] ld_dst = '0;
   logic [2:0] iss_idx = '0;
   logic [2:0] lat;
   logic       win_open;
   logic [NENT-1:0] inhibit, remove, abort_s;

   int n_chk = 0, n_fail = 0;

   // reference model state, indexed by issue cycle modulo 4
   int       cyc, cnt_m;
   bit       trk_m [4];
   bit       spc_m [4];
   bit [3:0] em [NENT];
   logic [NENT-1:0] obs_rm, obs_ab, obs_inh;
   logic       obs_win;
   logic [2:0] obs_lat;

   always #2.5 clk = ~clk;

   ldspec_window_ctl dut (
      .clk_i(clk), .rst_ni(rst_n), .ld_issue_i(ld_issue), .ld_fp_i(ld_fp),
      .ld_dst_i(ld_dst), .res_hit_i(res_hit), .iss_valid_i(iss_valid),
      .iss_idx_i(iss_idx), .lat_o(lat), .win_open_o(win_open),
      .inhibit_o(inhibit), .remove_o(remove), .abort_o(abort_s)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      cyc = 0; cnt_m = 15;
      for (int i = 0; i < 4; i++) begin trk_m[i] = 0; spc_m[i] = 0; end
      for (int e = 0; e < NENT; e++) em[e] = '0;
   endtask

   // one cycle: drive, compare against the model, then advance the model
   task automatic step(input bit ld, input bit fp, input int dst, input bit hit,
                       input bit iv, input int idx);
      int k;
      bit [3:0] openm;
      bit [3:0] nem [NENT];
      logic [NENT-1:0] e_rm, e_ab, e_inh;
      bit trk_new;
      @(negedge clk);
      ld_issue = ld; ld_fp = fp; ld_dst = 5'(dst); res_hit = hit;
      iss_valid = iv; iss_idx = 3'(idx);
      #1;
      k = (cyc + 1) % 4;
      openm = '0;
      if (spc_m[(cyc + 3) % 4]) openm[(cyc + 3) % 4] = 1'b1;
      if (spc_m[(cyc + 2) % 4]) openm[(cyc + 2) % 4] = 1'b1;
      e_rm = '0; e_ab = '0;
      for (int e = 0; e < NENT; e++) begin
         nem[e] = em[e];
         e_inh[e] = (em[e] != '0);
         if (spc_m[k] && em[e][k]) begin
            if (hit) begin nem[e][k] = 1'b0; e_rm[e] = (nem[e] == '0); end
            else     begin nem[e] = '0; e_ab[e] = 1'b1; end
         end
      end
      obs_rm = remove; obs_ab = abort_s; obs_inh = inhibit; obs_win = win_open; obs_lat = lat;
      if (ld) chk("R2 latency", int'(lat), fp ? 4 : (cnt_m >= 8 ? 3 : 5));
      chk("R3 window open", int'(win_open), int'(openm != '0));
      chk("R4 inhibit", int'(inhibit), int'(e_inh));
      chk("R5 remove", int'(remove), int'(e_rm));
      chk("R6 abort", int'(abort_s), int'(e_ab));
      // advance
      if (trk_m[k]) begin
         if (hit) cnt_m = (cnt_m + 1 > 15) ? 15 : cnt_m + 1;
         else     cnt_m = (cnt_m - 2 < 0) ? 0 : cnt_m - 2;
      end
      if (iv) nem[idx] = openm;
      trk_new = ld && !fp && (dst != 31);
      spc_m[cyc % 4] = trk_new && (cnt_m >= 8 || (trk_m[k] && 0));
      trk_m[cyc % 4] = trk_new;
      for (int e = 0; e < NENT; e++) em[e] = nem[e];
      cyc++;
   endtask

   // note: speculation decision uses the counter value before this cycle's update
   int cnt_before;

   task automatic step2(input bit ld, input bit fp, input int dst, input bit hit,
                        input bit iv, input int idx);
      cnt_before = cnt_m;
      step(ld, fp, dst, hit, iv, idx);
      spc_m[(cyc + 3) % 4] = trk_m[(cyc + 3) % 4] && (cnt_before >= 8);
   endtask

   task automatic idle(input bit hit);
      step2(0, 0, 0, hit, 0, 0);
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 reset inhibit", int'(inhibit), 0);
      chk("R1 reset window", int'(win_open), 0);
      chk("R1 reset latency", int'(lat), 3);

      // R5: hit removes both window consumers
      step2(1, 0, 5, 0, 0, 0);
      step2(0, 0, 0, 0, 1, 0);
      chk("R3 window after load", int'(obs_win), 1);
      step2(0, 0, 0, 0, 1, 1);
      step2(0, 0, 0, 1, 0, 0);
      chk("R5 remove on hit", int'(obs_rm), 3);
      idle(0);
      chk("R5 released after hit", int'(obs_inh), 0);

      // R6 and R4: independent consumer aborted on miss
      step2(1, 0, 7, 0, 0, 0);
      step2(0, 0, 0, 0, 1, 2);
      idle(0);
      chk("R4 held independent", int'(obs_inh), 4);
      step2(0, 0, 0, 0, 0, 0);
      chk("R6 abort on miss", int'(obs_ab), 4);
      idle(0);
      chk("R6 re-enabled", int'(obs_inh), 0);

      // R8 and R10: zero-register load opens nothing
      step2(1, 0, 31, 0, 0, 0);
      step2(0, 0, 0, 0, 1, 3);
      chk("R8 no window for r31", int'(obs_win), 0);
      idle(0);
      chk("R10 not inhibited", int'(obs_inh), 0);
      step2(0, 0, 0, 0, 0, 0);
      chk("R8 no abort", int'(obs_ab), 0);

      // R9: overlapping windows
      step2(1, 0, 4, 0, 0, 0);
      step2(1, 0, 6, 0, 1, 4);
      step2(0, 0, 0, 0, 1, 5);
      step2(0, 0, 0, 1, 0, 0);
      chk("R9 partial remove", int'(obs_rm), 16);
      step2(0, 0, 0, 0, 0, 0);
      chk("R9 abort on later miss", int'(obs_ab), 32);
      chk("R9 still held before", int'(obs_inh), 32);

      // R7: misses push the counter into safe mode, hits bring it back
      step2(1, 0, 1, 0, 0, 0);
      step2(1, 0, 2, 0, 0, 0);
      step2(1, 0, 3, 0, 0, 0);
      idle(0); idle(0); idle(0);
      step2(1, 0, 8, 0, 0, 0);
      chk("R7 safe latency after misses", int'(obs_lat), 5);
      step2(1, 0, 9, 0, 0, 0);
      chk("R3 no window in safe mode", int'(obs_win), 0);
      step2(1, 1, 9, 0, 0, 0);
      chk("R2 fp latency", int'(obs_lat), 4);
      step2(0, 0, 0, 1, 0, 0);
      step2(0, 0, 0, 1, 0, 0);
      step2(1, 0, 2, 0, 0, 0);
      chk("R7 recovered latency", int'(obs_lat), 3);
      idle(1); idle(1); idle(1);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit ld, fp, hit, iv;
         int dst, idx;
         ld  = ($urandom % 2) == 0;
         fp  = ($urandom % 7) == 0;
         dst = (($urandom % 7) == 0) ? 31 : int'($urandom % 31);
         hit = ($urandom % 10) < ((i / 500) % 2 == 0 ? 8 : 4);
         idx = int'($urandom % NENT);
         iv  = (($urandom % 5) < 3) && (em[idx] == '0);
         step2(ld, fp, dst, hit, iv, idx);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule